// File: doc/BRIEF.md
# Serial ADC Digital Interface Model

This block is a synthesizable, device-side model of the digital half of a 14-bit serial sampling converter. A host drives an active-low chip select, an optional frame-sync strobe and a serial clock. The model answers with a 16-bit word on serial data out, most significant bit first. All three host signals are sampled by a fast system clock, and every edge the model reacts to is found by comparing the current input with the value registered one system clock earlier.

Each frame is classified by the number of falling serial-clock edges it contained. A frame of one to eight edges is an initialization frame. A frame that reaches the conversion edge opens a sampling window on a parallel sample bus, freezes the held value, and starts a conversion timer measured in system clocks. The word sent in any frame is the previous frame's conversion result. A fixed status code is sent instead when the previous frame was an initialization frame, when it was cut short, or when the current frame began before the conversion timer had run out.

The model can stand in for a converter in a system simulation or an emulator. A host controller can also be checked against it.

Top module: `serial_adc_model`

## Requirements
- R1: From reset until the first initialization frame, `not_init` is 1, every bit shifted out is 0, and `converting` never rises, even for a frame of 24 or more falling edges.
- R2: A frame closed by chip select rising after 1 to 8 falling serial-clock edges clears `not_init`, and the following frame shifts out the status word 16'h3FC0.
- R3: With `HAS_FS` set, a frame is open only while `cs_n` and `fs` are both low. With `cs_n` already low, pulling `fs` low opens a frame, and `fs` going high closes it. Such a frame with 1 to 8 falling edges initializes the model exactly as in R2.
- R4: `sample_window` is 1 from the 4th falling edge of a frame until the 24th falling edge, and 0 at every other time.
- R5: On the 24th falling edge of an initialized frame, `converting` rises and stays high for `CONV_CYCLES` system clocks. The next frame then shifts out {sample, 2'b00}. The sample is the value of `sample_in` at the 24th falling edge, and later changes to `sample_in` have no effect on it.
- R6: A frame that opens while a conversion is still running abandons that conversion and shifts out 16'h3FC0.
- R7: A frame that opens in the same system clock in which the conversion timer expires is not an abort. It shifts out the freshly completed result.
- R8: An initialized frame closed after 9 to 23 falling edges makes the next frame shift out 16'h3FC0.
- R9: A frame with no falling edges leaves a pending result untouched, and the following frame still shifts it out.
- R10: Bit 15 appears on `sdo` after the 1st rising serial-clock edge of a frame, and each later rising edge presents the next lower bit. Bits 1:0 of a result word are 0, and every bit after the 16th rising edge is 0.
- R11: While no frame is open, `sdo_oe` and `sdo` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all host signals |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| fs | input | 1 | Frame-sync strobe; a frame also needs it low when `HAS_FS` is set |
| sclk | input | 1 | Serial clock from the host; idles low |
| sample_in | input | 14 | Parallel stand-in for the analog input |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_oe | output | 1 | High while a frame is open (data-out drive enable) |
| not_init | output | 1 | High until the first initialization frame |
| sample_window | output | 1 | High while the sample is being tracked |
| converting | output | 1 | High while the conversion timer runs |

## Verification
Two events can land in the same system clock: the conversion timer running out and the host opening the next frame. The bench closes a full frame and then opens the following one exactly `CONV_CYCLES` clocks after the 24th falling edge, where it expects the new result (R7). In a separate run it opens the next frame one clock earlier, where it expects 16'h3FC0 (R6). Both expected words come from the bench's own count of edges. A scoreboard compares each of them with the bits collected from `sdo`.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int unsigned SMP_W  = 14;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PAD_W  = WORD_W - SMP_W;

  localparam logic [WORD_W-1:0] STATUS_WORD = 16'h3FC0;

  typedef enum logic [1:0] {
    FR_EMPTY,
    FR_RESET,
    FR_SHORT,
    FR_FULL
  } frame_kind_e;

  // Place a sample in the upper bits of an output word; the padding bits are 0.
  function automatic logic [WORD_W-1:0] pack_result(input logic [SMP_W-1:0] s);
    return {s, {PAD_W{1'b0}}};
  endfunction

  // Decide what a frame was from its count of falling serial-clock edges.
  function automatic frame_kind_e classify(input int unsigned falls,
                                           input int unsigned reset_max,
                                           input int unsigned full_at);
    if (falls == 0)               return FR_EMPTY;
    else if (falls <= reset_max)  return FR_RESET;
    else if (falls < full_at)     return FR_SHORT;
    else                          return FR_FULL;
  endfunction

endpackage

// File: rtl/sadc_frame_tracker.sv
module sadc_frame_tracker
  import sadc_pkg::*;
#(
  parameter bit          HAS_FS    = 1'b1,
  parameter int unsigned RESET_MAX = 8,
  parameter int unsigned WIN_OPEN  = 4,
  parameter int unsigned CONV_AT   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        fs,
  input  logic        sclk,
  output logic        frame_act,
  output logic        frame_start,
  output logic        frame_end,
  output logic        sclk_rise,
  output logic        conv_point,
  output frame_kind_e end_kind,
  output logic        sample_window
);

  localparam int unsigned CNT_W = $clog2(CONV_AT + 2);
  localparam logic [CNT_W-1:0] CNT_TOP     = '1;
  localparam logic [CNT_W-1:0] OPEN_AT     = CNT_W'(WIN_OPEN);
  localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(CONV_AT - 1);

  logic             act_now;
  logic             act_q;
  logic             sclk_q;
  logic             sclk_fall;
  logic [CNT_W-1:0] fall_cnt;

  generate
    if (HAS_FS) begin : g_with_fs
      assign act_now = ~cs_n & ~fs;
    end else begin : g_cs_only
      assign act_now = ~cs_n;
    end
  endgenerate

  assign frame_start   = act_now & ~act_q;
  assign frame_end     = ~act_now & act_q;
  assign sclk_rise     = act_now & act_q & sclk & ~sclk_q;
  assign sclk_fall     = act_now & act_q & ~sclk & sclk_q;
  assign conv_point    = sclk_fall & (fall_cnt == LAST_BEFORE);
  assign end_kind      = classify(32'(fall_cnt), RESET_MAX, CONV_AT);
  assign sample_window = act_q & (fall_cnt >= OPEN_AT) & (fall_cnt <= LAST_BEFORE);
  assign frame_act     = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      sclk_q   <= 1'b0;
      fall_cnt <= '0;
    end else begin
      act_q  <= act_now;
      sclk_q <= sclk;
      if (frame_start) begin
        fall_cnt <= '0;
      end else if (sclk_fall && fall_cnt != CNT_TOP) begin
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

  assert_count_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fall_cnt == '0));

  assert_window_shut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_point |=> !sample_window);

endmodule

// File: rtl/sadc_conv_engine.sv
module sadc_conv_engine
  import sadc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 334
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  frame_kind_e       end_kind,
  input  logic              conv_point,
  input  logic              sample_window,
  input  logic [SMP_W-1:0]  sample_in,
  output logic              initialized,
  output logic              busy,
  output logic [WORD_W-1:0] load_word
);

  localparam int unsigned TMR_W = $clog2(CONV_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(CONV_CYCLES);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(1);

  logic [TMR_W-1:0]  tmr;
  logic [SMP_W-1:0]  hold;
  logic [WORD_W-1:0] out_word;
  logic              conv_go;
  logic              conv_done;
  logic              abort;
  logic              status_end;

  assign conv_go    = conv_point & initialized;
  assign conv_done  = busy & (tmr == TMR_LAST);
  assign abort      = frame_start & busy & ~conv_done;
  assign status_end = frame_end &
                      ((end_kind == FR_RESET) || (end_kind == FR_SHORT && initialized));

  // The word handed to the serializer at frame start; a result that
  // completes in the same cycle is forwarded straight from the hold register.
  always_comb begin
    if (!initialized)   load_word = '0;
    else if (conv_done) load_word = pack_result(hold);
    else if (busy)      load_word = STATUS_WORD;
    else                load_word = out_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (sample_window) begin
      hold <= sample_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (conv_go) begin
      busy <= 1'b1;
      tmr  <= TMR_LOAD;
    end else if (conv_done || abort) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (busy) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      initialized <= 1'b0;
      out_word    <= '0;
    end else begin
      if (frame_end && end_kind == FR_RESET) initialized <= 1'b1;
      if (conv_done)                  out_word <= pack_result(hold);
      else if (abort || status_end)   out_word <= STATUS_WORD;
    end
  end

  assert_no_conv_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !initialized |-> !busy);

  assert_conv_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> busy);

  assert_abort_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && out_word == STATUS_WORD));

  assert_status_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && end_kind == FR_RESET) |=> (initialized && out_word == STATUS_WORD));

  assert_done_not_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && conv_done) |=> (out_word == pack_result($past(hold))));

endmodule

// File: rtl/sadc_shift_out.sv
module sadc_shift_out
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              frame_start,
  input  logic              sclk_rise,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo,
  output logic              sdo_oe
);

  logic [WORD_W-1:0] sh;
  logic              sdo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      sdo_q <= 1'b0;
    end else if (frame_start) begin
      sh    <= load_word;
      sdo_q <= 1'b0;
    end else if (sclk_rise) begin
      sdo_q <= sh[WORD_W-1];
      sh    <= {sh[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_oe = frame_act;
  assign sdo    = frame_act & sdo_q;

  assert_quiet_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

endmodule

// File: rtl/serial_adc_model.sv
module serial_adc_model
  import sadc_pkg::*;
#(
  parameter bit          HAS_FS      = 1'b1,
  parameter int unsigned RESET_MAX   = 8,
  parameter int unsigned WIN_OPEN    = 4,
  parameter int unsigned WIN_LEN     = 20,
  parameter int unsigned CONV_CYCLES = 334
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fs,
  input  logic             sclk,
  input  logic [SMP_W-1:0] sample_in,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             not_init,
  output logic             sample_window,
  output logic             converting
);

  localparam int unsigned CONV_AT = WIN_OPEN + WIN_LEN;

  logic              frame_act;
  logic              frame_start;
  logic              frame_end;
  logic              sclk_rise;
  logic              conv_point;
  frame_kind_e       end_kind;
  logic              initialized;
  logic              busy;
  logic [WORD_W-1:0] load_word;

  sadc_frame_tracker #(
    .HAS_FS   (HAS_FS),
    .RESET_MAX(RESET_MAX),
    .WIN_OPEN (WIN_OPEN),
    .CONV_AT  (CONV_AT)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .fs           (fs),
    .sclk         (sclk),
    .frame_act    (frame_act),
    .frame_start  (frame_start),
    .frame_end    (frame_end),
    .sclk_rise    (sclk_rise),
    .conv_point   (conv_point),
    .end_kind     (end_kind),
    .sample_window(sample_window)
  );

  sadc_conv_engine #(
    .CONV_CYCLES(CONV_CYCLES)
  ) u_conv (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .frame_end    (frame_end),
    .end_kind     (end_kind),
    .conv_point   (conv_point),
    .sample_window(sample_window),
    .sample_in    (sample_in),
    .initialized  (initialized),
    .busy         (busy),
    .load_word    (load_word)
  );

  sadc_shift_out u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_act  (frame_act),
    .frame_start(frame_start),
    .sclk_rise  (sclk_rise),
    .load_word  (load_word),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  assign not_init   = ~initialized;
  assign converting = busy;

  assert_no_data_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (not_init && sdo_oe) |-> !sdo);

endmodule

// File: tb/serial_adc_model_tb.sv
`timescale 1ns/1ps
module serial_adc_model_tb;

  localparam int CONV = 40;

  typedef struct {
    logic [15:0] w;
    int          nb;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        fs = 1'b0;
  logic        sclk = 1'b0;
  logic [13:0] sample_in = '0;
  logic        sdo, sdo_oe, not_init, sample_window, converting;

  int          vectors = 0;
  int          errs = 0;
  bit          finished = 1'b0;
  exp_t        exp_q[$];
  logic [15:0] obs_word;
  int          last_winbad, last_tail;
  logic        conv_flag;
  event        obs_ev;

  always #4 clk = ~clk;

  serial_adc_model #(.CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .not_init(not_init),
    .sample_window(sample_window), .converting(converting)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] as_word(input logic [13:0] s);
    return 16'(s) << 2;
  endfunction

  // Driver: pushes the expected word, then clocks a frame and collects sdo.
  task automatic run_frame(input int n, input logic [13:0] smp, input bit via_fs,
                           input logic [15:0] expw, input string tag);
    logic [15:0] cap;
    int tail, winbad;
    exp_t e;
    cap = '0; tail = 0; winbad = 0; conv_flag = 1'b0;
    if (n > 0) begin
      e.w = expw; e.nb = (n < 16) ? n : 16; e.tag = tag;
      exp_q.push_back(e);
    end
    sample_in = smp;
    if (via_fs) fs = 1'b0; else cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 1; i <= n; i++) begin
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      if (i <= 16) cap[16-i] = sdo;
      else if (sdo) tail++;
      sclk = 1'b0;
      @(negedge clk);
      if (sample_window !== (i >= 4 && i < 24)) winbad++;
      if (i == 24) conv_flag = converting;
      if (i == n) sample_in = ~smp;
      @(negedge clk);
    end
    if (via_fs) fs = 1'b1; else cs_n = 1'b1;
    last_winbad = winbad;
    last_tail = tail;
    if (n > 0) begin
      obs_word = cap;
      -> obs_ev;
    end
  endtask

  task automatic gap(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Monitor: pops the oldest expectation and compares the collected bits.
  initial begin
    forever begin
      logic [15:0] mask;
      exp_t e;
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        mask = 16'hFFFF << (16 - e.nb);
        check(e.tag, 32'(obs_word & mask), 32'(e.w & mask));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R11: reset state
    check("R1 not_init after reset", 32'(not_init), 32'd1);
    check("R11 sdo_oe idle", 32'(sdo_oe), 32'd0);
    check("R11 sdo idle", 32'(sdo), 32'd0);
    check("R1 converting after reset", 32'(converting), 32'd0);

    // R1: full frame before initialization gives zeros and no conversion
    run_frame(24, 14'h1ABC, 1'b0, 16'h0000, "R1 pre-init data zero");
    check("R1 no conversion before init", 32'(conv_flag), 32'd0);
    gap(CONV + 5);
    check("R1 still not initialized", 32'(not_init), 32'd1);

    // R3: initialization through frame sync with chip select already low
    fs = 1'b1; @(negedge clk);
    cs_n = 1'b0; @(negedge clk);
    run_frame(3, 14'h0, 1'b1, 16'h0000, "R3 fs frame data");
    @(negedge clk);
    check("R3 fs reset clears not_init", 32'(not_init), 32'd0);
    cs_n = 1'b1; @(negedge clk);
    fs = 1'b0; gap(4);

    // R3/R2: first frame after initialization shows the status word
    run_frame(24, 14'h2A5C, 1'b0, 16'h3FC0, "R3 status after fs reset");
    check("R4 window timing", 32'(last_winbad), 32'd0);
    check("R5 converting at 24th edge", 32'(conv_flag), 32'd1);
    gap(CONV + 5);
    check("R5 converting ends", 32'(converting), 32'd0);
    check("R11 sdo_oe low between frames", 32'(sdo_oe), 32'd0);

    // R5 / R10: previous result, later sample change ignored
    run_frame(24, 14'h1337, 1'b0, as_word(14'h2A5C), "R5 R10 result word");
    check("R4 window timing second frame", 32'(last_winbad), 32'd0);
    gap(CONV + 5);

    // R9: empty frame keeps pending result
    run_frame(0, 14'h0, 1'b0, 16'h0, "R9 empty");
    gap(3);
    run_frame(24, 14'h3FFF, 1'b0, as_word(14'h1337), "R9 result survives empty frame");

    // R6: open the next frame one clock before the timer expires
    gap(CONV - 3);
    run_frame(24, 14'h0001, 1'b0, 16'h3FC0, "R6 abort gives status");

    // R7: open the next frame in the very clock the timer expires
    gap(CONV - 2);
    run_frame(24, 14'h2000, 1'b0, as_word(14'h0001), "R7 same-cycle completion");
    gap(CONV + 5);

    // R8: short frame then status
    run_frame(12, 14'h0777, 1'b0, as_word(14'h2000), "R8 short frame data");
    gap(5);
    run_frame(24, 14'h15A3, 1'b0, 16'h3FC0, "R8 status after short frame");
    gap(CONV + 5);

    // R2: re-initialization through chip select
    run_frame(6, 14'h0, 1'b0, as_word(14'h15A3), "R2 reset frame data");
    gap(5);
    run_frame(24, 14'h0F0F, 1'b0, 16'h3FC0, "R2 status after reset frame");
    gap(CONV + 5);

    // R10: bits past the 16th rising edge are zero
    run_frame(30, 14'h3210, 1'b0, as_word(14'h0F0F), "R10 long frame word");
    check("R10 tail bits zero", 32'(last_tail), 32'd0);
    gap(CONV + 5);
    run_frame(24, 14'h0, 1'b0, as_word(14'h3210), "R5 result of long frame");
    gap(4);
    check("R11 sdo idle at end", 32'({sdo_oe, sdo}), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule